// File: doc/BRIEF.md
# Indirect PHY Register Read Bridge

This block lets an 8-bit host register bus read the 16-bit management registers of a PHY without touching the management wires itself. The host loads a target register offset and a 2-bit PHY address field into an address register. It then writes a command register that names the target and requests a read. While the bridge serialises an MDIO-style read frame, a busy flag is visible in the command register. When the flag drops, the 16-bit result is held in two byte-wide data registers. The host then retires the operation by writing the command again with the read bit cleared, which keeps the target selection and starts nothing.

The same command register has a target bit that chooses between the PHY and a serial EEPROM. Only the PHY path is modelled. An EEPROM read request only raises the busy flag for a fixed stub delay. It leaves the management wires idle and does not change the data registers. The PHY-side serial clock is the system clock divided by a parameter.

Host offsets: command/status at 0x0B, address at 0x0C, result low byte at 0x0D, result high byte at 0x0E. Reads of any other offset return 0.

Top module: `phy_mgmt_bridge`

## Requirements
- R1: After reset the address register reads 0x40 (PHY field 01, offset 0), the command register reads 0x00, and both data registers read 0x00.
- R2: The address register keeps the register offset in bits [4:0] and the PHY field in bits [7:6]. Bit 5 always reads 0.
- R3: When the bridge is idle, a command write with bit 2 set starts a read. From the next cycle the command register reads {4'b0, target bit 3, read bit 2, 1'b0, busy bit 0}, with busy = 1.
- R4: With target bit 3 = 1, the bridge sends 32 ones, then 01, then 10, then the 5-bit PHY address {000, field}, then the 5-bit offset, all MSB first with the data line driven. It then releases the line for 2 turnaround bits and 16 data bits, so 64 MDC rising edges make up one frame.
- R5: MDC has a period of 2*HALF_DIV system clocks during a frame and is held low whenever the bridge is not busy.
- R6: The data bits sampled on the MDC rising edges, MSB first, become the result. The high byte reads at 0x0E and the low byte at 0x0D once busy drops.
- R7: A PHY read holds busy for fewer than BUSY_LIMIT cycles (500 cycles = 5 us at 100 MHz by default).
- R8: A command write of 0x08 clears the read bit, keeps the PHY target, and starts no access: busy stays 0 and MDC stays idle.
- R9: Any command write while busy is 1 is ignored. The stored bits do not change and no second frame starts.
- R10: With target bit 3 = 0, a read command holds busy for STUB_CYC cycles, produces no MDC or data-line activity, and leaves the data registers unchanged.
- R11: The data registers keep their previous value during a new read and change only when that read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Host write strobe, one cycle per write |
| bus_addr_i | input | 8 | Host register offset |
| bus_wdata_i | input | 8 | Host write data |
| bus_rdata_o | output | 8 | Host read data, combinational on bus_addr_i |
| mdc_o | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in from the PHY |

## Verification
A wrong frame sequencer shows up on the management wires within one frame (about 256 cycles). A shifted header bit changes the captured address and offset. A wrong sample point or bit order scrambles the returned word at 0x0D/0x0E the moment busy drops. A stuck or early-clearing busy flag is seen on the next poll of 0x0B: either the busy bit never drops inside the 5 us window or the result is read before all 16 bits arrive. Command-state faults, such as a retire write that restarts the frame or a write accepted while busy, show up as extra MDC edges or altered command bits on the very next read of the command register.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 16;
  localparam int OFF_W    = 5;
  localparam int FLD_W    = 2;
  localparam int PRE_LEN  = 32;
  localparam int HDR_LEN  = PRE_LEN + 4 + 5 + OFF_W;   // driven part of frame
  localparam int TA_LEN   = 2;
  localparam int FRM_LEN  = HDR_LEN + TA_LEN + WORD_W;
  localparam int IDX_W    = $clog2(FRM_LEN);

  localparam logic [BYTE_W-1:0] OFS_CMD  = 8'h0B;
  localparam logic [BYTE_W-1:0] OFS_ADDR = 8'h0C;
  localparam logic [BYTE_W-1:0] OFS_DLO  = 8'h0D;
  localparam logic [BYTE_W-1:0] OFS_DHI  = 8'h0E;

  localparam int CMD_BUSY_BIT = 0;
  localparam int CMD_RD_BIT   = 2;
  localparam int CMD_TGT_BIT  = 3;

  localparam logic [FLD_W-1:0] FLD_RST = 2'b01;
endpackage

// File: rtl/mdio_read_master.sv
module mdio_read_master
  import mgmt_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [FLD_W-1:0]  phy_fld_i,
  input  logic [OFF_W-1:0]  reg_off_i,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HALF_DIV - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRM_LEN - 1);
  localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(HDR_LEN + TA_LEN);
  localparam logic [IDX_W-1:0] IDX_REL  = IDX_W'(HDR_LEN);

  logic              run_q, mdc_q, done_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [HDR_LEN-1:0] hdr_q;
  logic [WORD_W-1:0] shf_q;
  logic              tick;

  assign tick = run_q && (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      mdc_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      hdr_q  <= '0;
      shf_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !run_q) begin
        run_q <= 1'b1;
        mdc_q <= 1'b0;
        cnt_q <= '0;
        idx_q <= '0;
        hdr_q <= {{PRE_LEN{1'b1}}, 2'b01, 2'b10, {(5-FLD_W){1'b0}}, phy_fld_i, reg_off_i};
      end else if (tick) begin
        cnt_q <= '0;
        mdc_q <= ~mdc_q;
        if (!mdc_q) begin
          // rising MDC: PHY data is stable here
          if (idx_q >= IDX_DATA) shf_q <= {shf_q[WORD_W-2:0], mdio_i};
        end else if (idx_q == IDX_LAST) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
          hdr_q <= {hdr_q[HDR_LEN-2:0], 1'b0};
        end
      end else if (run_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign mdc_o     = mdc_q;
  assign mdio_oe_o = run_q && (idx_q < IDX_REL);
  assign mdio_o    = mdio_oe_o & hdr_q[HDR_LEN-1];
  assign done_o    = done_q;
  assign word_o    = shf_q;
endmodule

// File: rtl/mgmt_host_regs.sv
module mgmt_host_regs
  import mgmt_pkg::*;
#(
  parameter int STUB_CYC = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BYTE_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              phy_start_o,
  output logic [FLD_W-1:0]  phy_fld_o,
  output logic [OFF_W-1:0]  reg_off_o,
  input  logic              mdio_done_i,
  input  logic [WORD_W-1:0] mdio_word_i,
  output logic              busy_o,
  output logic              tgt_phy_o,
  output logic [1:0]        cmd_bits_o,
  output logic [WORD_W-1:0] result_o
);
  localparam int SC_W = (STUB_CYC > 1) ? $clog2(STUB_CYC) : 1;

  logic [FLD_W-1:0]  fld_q;
  logic [OFF_W-1:0]  off_q;
  logic              sel_q, rd_q, busy_q, tgt_q;
  logic [SC_W-1:0]   stub_q;
  logic [WORD_W-1:0] res_q;
  logic              cmd_wr, start, fin;

  assign cmd_wr = we_i && (addr_i == OFS_CMD) && !busy_q;
  assign start  = cmd_wr && wdata_i[CMD_RD_BIT];
  assign fin    = busy_q && (tgt_q ? mdio_done_i : (stub_q == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fld_q  <= FLD_RST;
      off_q  <= '0;
      sel_q  <= 1'b0;
      rd_q   <= 1'b0;
      busy_q <= 1'b0;
      tgt_q  <= 1'b0;
      stub_q <= '0;
      res_q  <= '0;
    end else begin
      if (we_i && addr_i == OFS_ADDR) begin
        fld_q <= wdata_i[7:6];
        off_q <= wdata_i[OFF_W-1:0];
      end
      if (cmd_wr) begin
        sel_q <= wdata_i[CMD_TGT_BIT];
        rd_q  <= wdata_i[CMD_RD_BIT];
      end
      if (start) begin
        busy_q <= 1'b1;
        tgt_q  <= wdata_i[CMD_TGT_BIT];
        stub_q <= SC_W'(STUB_CYC - 1);
      end else if (fin) begin
        busy_q <= 1'b0;
      end else if (busy_q && !tgt_q) begin
        stub_q <= stub_q - 1'b1;
      end
      if (busy_q && tgt_q && mdio_done_i) res_q <= mdio_word_i;
    end
  end

  always_comb begin
    unique case (addr_i)
      OFS_CMD:  rdata_o = {4'b0, sel_q, rd_q, 1'b0, busy_q};
      OFS_ADDR: rdata_o = {fld_q, 1'b0, off_q};
      OFS_DLO:  rdata_o = res_q[7:0];
      OFS_DHI:  rdata_o = res_q[15:8];
      default:  rdata_o = '0;
    endcase
  end

  assign phy_start_o = start && wdata_i[CMD_TGT_BIT];
  assign phy_fld_o   = fld_q;
  assign reg_off_o   = off_q;
  assign busy_o      = busy_q;
  assign tgt_phy_o   = tgt_q;
  assign cmd_bits_o  = {sel_q, rd_q};
  assign result_o    = res_q;
endmodule

// File: rtl/phy_mgmt_bridge.sv
module phy_mgmt_bridge
  import mgmt_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int STUB_CYC = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [BYTE_W-1:0] bus_addr_i,
  input  logic [BYTE_W-1:0] bus_wdata_i,
  output logic [BYTE_W-1:0] bus_rdata_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  logic              phy_start, mdio_done, busy, tgt_phy;
  logic [FLD_W-1:0]  phy_fld;
  logic [OFF_W-1:0]  reg_off;
  logic [WORD_W-1:0] mdio_word, result;
  logic [1:0]        cmd_bits;

  mgmt_host_regs #(.STUB_CYC(STUB_CYC)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (bus_we_i),
    .addr_i      (bus_addr_i),
    .wdata_i     (bus_wdata_i),
    .rdata_o     (bus_rdata_o),
    .phy_start_o (phy_start),
    .phy_fld_o   (phy_fld),
    .reg_off_o   (reg_off),
    .mdio_done_i (mdio_done),
    .mdio_word_i (mdio_word),
    .busy_o      (busy),
    .tgt_phy_o   (tgt_phy),
    .cmd_bits_o  (cmd_bits),
    .result_o    (result)
  );

  mdio_read_master #(.HALF_DIV(HALF_DIV)) u_mdio (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (phy_start),
    .phy_fld_i (phy_fld),
    .reg_off_i (reg_off),
    .mdc_o     (mdc_o),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .mdio_i    (mdio_i),
    .done_o    (mdio_done),
    .word_o    (mdio_word)
  );
endmodule

// File: rtl/phy_mgmt_bridge_chk.sv
module phy_mgmt_bridge_chk
  import mgmt_pkg::*;
#(
  parameter int BUSY_LIMIT = 500
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic [BYTE_W-1:0] bus_addr_i,
  input logic [BYTE_W-1:0] bus_wdata_i,
  input logic              mdc_o,
  input logic              mdio_oe_o,
  input logic              busy,
  input logic              tgt_phy,
  input logic              mdio_done,
  input logic [1:0]        cmd_bits,
  input logic [WORD_W-1:0] result
);
  localparam int BC_W = $clog2(BUSY_LIMIT + 1);
  logic [BC_W-1:0] busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_cnt <= '0;
    else if (!busy) busy_cnt <= '0;
    else if (busy_cnt != BC_W'(BUSY_LIMIT)) busy_cnt <= busy_cnt + 1'b1;
  end

  assert_start_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(bus_we_i && bus_addr_i == OFS_CMD && bus_wdata_i[CMD_RD_BIT]));

  assert_drive_only_phy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_oe_o |-> (busy && tgt_phy));

  assert_mdc_idle_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdc_o);

  assert_busy_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_cnt < BC_W'(BUSY_LIMIT));

  assert_cmd_locked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && bus_we_i && bus_addr_i == OFS_CMD) |=> $stable(cmd_bits));

  assert_stub_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !tgt_phy) |-> (!mdc_o && !mdio_oe_o));

  assert_result_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mdio_done |=> $stable(result));
endmodule

bind phy_mgmt_bridge phy_mgmt_bridge_chk #(.BUSY_LIMIT(500)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .mdc_o       (mdc_o),
  .mdio_oe_o   (mdio_oe_o),
  .busy        (busy),
  .tgt_phy     (tgt_phy),
  .mdio_done   (mdio_done),
  .cmd_bits    (cmd_bits),
  .result      (result)
);

// File: tb/phy_mgmt_bridge_tb.sv
`timescale 1ns/1ps
module phy_mgmt_bridge_tb;
  localparam int HALF_DIV   = 2;
  localparam int STUB_CYC   = 20;
  localparam int BUSY_LIMIT = 500;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       mdc, mdio_out, mdio_oe;
  logic       mdio_in = 1'b1;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  phy_mgmt_bridge #(.HALF_DIV(HALF_DIV), .STUB_CYC(STUB_CYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .mdc_o(mdc), .mdio_o(mdio_out),
    .mdio_oe_o(mdio_oe), .mdio_i(mdio_in)
  );

  // PHY model
  logic [15:0] phy_mem [32];
  logic [45:0] hdr_cap = '0;
  int  pc = 0;
  int  tot_rise = 0;
  time last_rise = 0;
  time mdc_per = 0;

  always @(posedge mdc) begin
    pc = (pc == 64) ? 1 : pc + 1;
    tot_rise = tot_rise + 1;
    if (mdio_oe) hdr_cap = {hdr_cap[44:0], mdio_out};
    if (last_rise != 0) mdc_per = $time - last_rise;
    last_rise = $time;
  end

  always @(negedge mdc) begin
    if (pc >= 48 && pc < 64) mdio_in = phy_mem[hdr_cap[4:0]][15 - (pc - 48)];
    else mdio_in = 1'b1;
  end

  function automatic logic [45:0] exp_hdr(input logic [1:0] f, input logic [4:0] o);
    return {32'hFFFF_FFFF, 2'b01, 2'b10, 3'b000, f, o};
  endfunction

  function automatic logic [7:0] exp_cmd(input bit sel, input bit rd, input bit bsy);
    return {4'b0, sel, rd, 1'b0, bsy};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [7:0] c;
    n = 0;
    rd(8'h0B, c);
    while (c[0] && n < 700) begin
      @(negedge clk);
      n++;
      rd(8'h0B, c);
    end
  endtask

  task automatic phy_read(input logic [1:0] f, input bit b5, input logic [4:0] o);
    logic [7:0] v, hi, lo;
    int n, r0;
    wr(8'h0C, {f, b5, o});
    rd(8'h0C, v);
    chk("R2 addr readback", v, {f, 1'b0, o});
    r0 = tot_rise;
    wr(8'h0B, 8'h0C);
    rd(8'h0B, v);
    chk("R3 busy after start", v, exp_cmd(1, 1, 1));
    wait_idle(n);
    chk("R7 busy below limit", (n < BUSY_LIMIT), 1);
    rd(8'h0E, hi);
    rd(8'h0D, lo);
    chk("R6 result word", {hi, lo}, phy_mem[o]);
    chk("R4 header bits", hdr_cap, exp_hdr(f, o));
    chk("R4 frame edges", tot_rise - r0, 64);
    chk("R5 mdc period", mdc_per, 2 * HALF_DIV * 10);
    wr(8'h0B, 8'h08);
    rd(8'h0B, v);
    chk("R8 retire value", v, exp_cmd(1, 0, 0));
    repeat (20) @(negedge clk);
    chk("R8 no new frame", tot_rise - r0, 64);
    rd(8'h0B, v);
    chk("R8 still idle", v, exp_cmd(1, 0, 0));
  endtask

  initial begin
    logic [7:0] v, hi, lo;
    logic [15:0] old;
    int n, r0;
    void'($urandom(32'd2024));
    for (int i = 0; i < 32; i++) phy_mem[i] = 16'($urandom);
    phy_mem[7] = ~phy_mem[5];

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h0C, v); chk("R1 addr reset", v, 8'h40);
    rd(8'h0B, v); chk("R1 cmd reset", v, 8'h00);
    rd(8'h0D, v); chk("R1 lo reset", v, 8'h00);
    rd(8'h0E, v); chk("R1 hi reset", v, 8'h00);

    // directed: default field, offset 0 and 31
    phy_read(2'b01, 1'b0, 5'd0);
    phy_read(2'b01, 1'b1, 5'd31);

    // R9: writes while busy ignored
    wr(8'h0C, {2'b01, 1'b0, 5'd5});
    r0 = tot_rise;
    wr(8'h0B, 8'h0C);
    repeat (10) @(negedge clk);
    wr(8'h0B, 8'h00);
    rd(8'h0B, v);
    chk("R9 cmd unchanged", v, exp_cmd(1, 1, 1));
    wr(8'h0B, 8'h0C);
    wait_idle(n);
    repeat (10) @(negedge clk);
    chk("R9 single frame", tot_rise - r0, 64);
    rd(8'h0E, hi); rd(8'h0D, lo);
    chk("R9 first result", {hi, lo}, phy_mem[5]);
    wr(8'h0B, 8'h08);

    // R11: old data held during new read
    old = phy_mem[5];
    wr(8'h0C, {2'b01, 1'b0, 5'd7});
    wr(8'h0B, 8'h0C);
    repeat (100) @(negedge clk);
    rd(8'h0E, hi); rd(8'h0D, lo);
    chk("R11 hold mid read", {hi, lo}, old);
    wait_idle(n);
    rd(8'h0E, hi); rd(8'h0D, lo);
    chk("R11 updated at end", {hi, lo}, phy_mem[7]);
    wr(8'h0B, 8'h08);

    // R10: EEPROM target stub
    old = phy_mem[7];
    r0 = tot_rise;
    wr(8'h0B, 8'h04);
    rd(8'h0B, v);
    chk("R10 stub busy", v, exp_cmd(0, 1, 1));
    wait_idle(n);
    chk("R10 stub length", (n >= STUB_CYC - 2 && n <= STUB_CYC + 1), 1);
    chk("R10 no mdc", tot_rise - r0, 0);
    rd(8'h0E, hi); rd(8'h0D, lo);
    chk("R10 data kept", {hi, lo}, old);
    wr(8'h0B, 8'h00);

    // random reads
    for (int k = 0; k < 6; k++) begin
      logic [1:0] f;
      logic [4:0] o;
      bit b;
      f = 2'($urandom);
      o = 5'($urandom);
      b = 1'($urandom);
      phy_read(f, b, o);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule